// File: doc/BRIEF.md
# Keyed-Lock GPIO Pad Mode Controller

This block runs one memory-mapped port of up to 32 general-purpose pins. Each populated pin holds an output data bit and a two-bit drive mode formed from a high mode bit and a low mode bit. The mode and data bit together choose what the pad does: it stays high-impedance as an input, drives the data bit push-pull, only sinks low, or only sources high. The block gives registered output-value and output-enable vectors for external tri-state pad cells. Pad inputs pass through a two-flop synchronizer, and software reads the result.

Software reaches the block over a plain 32-bit register bus. It writes and reads in one cycle, and read data is registered. Mode state is guarded. A guard register becomes armed only when a fixed 16-bit key is written into its low half. Any mode write made while the guard is not armed is dropped with no error. Data bits can be changed at any time through write-one-to-set and write-one-to-clear registers. The parameter `NUM_PINS` sets how many pins are populated. Unpopulated pins never drive and always read 0.

Top module: `gpio_padmode_ctrl`

## Requirements
- R1: After synchronous reset, all mode bits, data bits and the guard are 0, so every pad is an input, `pad_oe` and `pad_out` are all 0, and reads of the mode (0x08, 0x0C), data (0x14) and guard (0x60) registers return 0.
- R2: Mode {high,low}=00 makes the pin an input: `pad_oe` is 0 and `pad_out` is 0 whatever the data bit holds.
- R3: Mode 01 is push-pull: `pad_oe` is 1 and `pad_out` equals the data bit.
- R4: Mode 10 sinks only: `pad_out` is 0 and `pad_oe` is 1 when the data bit is 0 and 0 when it is 1.
- R5: Mode 11 sources only: `pad_out` is 1 and `pad_oe` is 1 when the data bit is 1 and 0 when it is 0.
- R6: A write to the guard register (0x60) whose bits [15:0] equal 0xD42F arms the guard. A write with bits [15:0] equal to 0 disarms it. Any other value leaves it as it was. A read of 0x60 returns the armed state in bit 31 and 0 in all other bits.
- R7: Writes to the mode registers take effect only while the guard is armed. These are direct high-mode (0x08), direct low-mode (0x0C), high-mode clear (0x50), low-mode set (0x54) and low-mode clear (0x58). While the guard is disarmed they are dropped and the mode bits keep their values.
- R8: Data set (0x14), data clear (0x18) and the mode set/clear registers change only the pins whose write bit is 1. A 0 bit leaves that pin unchanged. A read of 0x14 returns the data bits.
- R9: The pad input reaches the data-in register (0x04) through two flops. A read issued in the cycle after a pad change, or the cycle after that, still returns the old value. The read issued after that returns the new value.
- R10: Pins at or above `NUM_PINS` never drive (`pad_oe`=0, `pad_out`=0) and read 0 in every pin-wide register.
- R11: `bus_rdata` carries the value addressed in the cycle after `bus_rd` is high. It is 0 in cycles with no read, and it is 0 for a read of an unmapped offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Asynchronous pad input levels |
| pad_out | output | 32 | Value driven on each pad when enabled |
| pad_oe | output | 32 | Per-pad output enable, 1 = drive |

## Verification
A register write takes effect at the clock edge that samples it. The pad outputs follow one edge later, because the encoder registers them. The bench therefore lets one more edge pass after each write and samples on the falling edge that follows. Read data appears one edge after the strobe, so each read is sampled on the falling edge right after its capture edge. Pad-input changes are read three times in a row, which brackets the two-flop delay: the first two reads must show the old value and the third the new one.

// File: rtl/gpio_padmode_pkg.sv
package gpio_padmode_pkg;
  localparam int unsigned MAX_PINS = 32;
  localparam int unsigned BUS_DW   = 32;
  localparam int unsigned BUS_AW   = 8;
  localparam int unsigned KEY_W    = 16;

  localparam logic [BUS_AW-1:0] OFS_PIN_IN     = 8'h04;
  localparam logic [BUS_AW-1:0] OFS_DRV_HI     = 8'h08;
  localparam logic [BUS_AW-1:0] OFS_DRV_LO     = 8'h0C;
  localparam logic [BUS_AW-1:0] OFS_OUT_SET    = 8'h14;
  localparam logic [BUS_AW-1:0] OFS_OUT_CLR    = 8'h18;
  localparam logic [BUS_AW-1:0] OFS_DRV_HI_CLR = 8'h50;
  localparam logic [BUS_AW-1:0] OFS_DRV_LO_SET = 8'h54;
  localparam logic [BUS_AW-1:0] OFS_DRV_LO_CLR = 8'h58;
  localparam logic [BUS_AW-1:0] OFS_GUARD      = 8'h60;

  localparam logic [KEY_W-1:0] GUARD_ARM_KEY = 16'hD42F;
  localparam logic [KEY_W-1:0] GUARD_DISARM  = 16'h0000;

  typedef enum logic [1:0] {
    PM_INPUT    = 2'b00,
    PM_PUSHPULL = 2'b01,
    PM_SINK     = 2'b10,
    PM_SOURCE   = 2'b11
  } pad_mode_e;
endpackage

// File: rtl/gpio_guard_lock.sv
module gpio_guard_lock
  import gpio_padmode_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [KEY_W-1:0] key_in,
  output logic             armed
);
  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
    end else if (wr_en) begin
      if (key_in == GUARD_ARM_KEY)      armed <= 1'b1;
      else if (key_in == GUARD_DISARM)  armed <= 1'b0;
    end
  end

  // R6: the key arms, zero disarms, anything else holds
  a_r6_key_arms: assert property (@(posedge clk) disable iff (rst)
    (wr_en && key_in == GUARD_ARM_KEY) |=> armed);
  a_r6_zero_disarms: assert property (@(posedge clk) disable iff (rst)
    (wr_en && key_in == GUARD_DISARM) |=> !armed);
  a_r6_other_holds: assert property (@(posedge clk) disable iff (rst)
    (wr_en && key_in != GUARD_ARM_KEY && key_in != GUARD_DISARM) |=> $stable(armed));
endmodule

// File: rtl/gpio_drive_regs.sv
module gpio_drive_regs #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         unlocked,
  input  logic         wr_hi,
  input  logic         wr_lo,
  input  logic         clr_hi,
  input  logic         set_lo,
  input  logic         clr_lo,
  input  logic         set_out,
  input  logic         clr_out,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] drv_hi,
  output logic [N-1:0] drv_lo,
  output logic [N-1:0] out_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      drv_hi <= '0;
      drv_lo <= '0;
    end else if (unlocked) begin
      if (wr_hi)       drv_hi <= wdata;
      else if (clr_hi) drv_hi <= drv_hi & ~wdata;
      if (wr_lo)       drv_lo <= wdata;
      else if (set_lo) drv_lo <= drv_lo | wdata;
      else if (clr_lo) drv_lo <= drv_lo & ~wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          out_q <= '0;
    else if (set_out) out_q <= out_q | wdata;
    else if (clr_out) out_q <= out_q & ~wdata;
  end

  // R7: a disarmed guard freezes both mode vectors
  a_r7_modes_frozen: assert property (@(posedge clk) disable iff (rst)
    !unlocked |=> ($stable(drv_hi) && $stable(drv_lo)));
  // R8: set touches only ones, clear only ones
  a_r8_set_keeps_others: assert property (@(posedge clk) disable iff (rst)
    set_out |=> ((out_q & ~$past(wdata)) == ($past(out_q) & ~$past(wdata))));
  a_r8_clear_keeps_others: assert property (@(posedge clk) disable iff (rst)
    clr_out |=> ((out_q & ~$past(wdata)) == ($past(out_q) & ~$past(wdata))));
endmodule

// File: rtl/gpio_pad_encode.sv
module gpio_pad_encode
  import gpio_padmode_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] drv_hi,
  input  logic [N-1:0] drv_lo,
  input  logic [N-1:0] dat,
  output logic [N-1:0] pad_out,
  output logic [N-1:0] pad_oe
);
  for (genvar i = 0; i < N; i++) begin : g_pin
    pad_mode_e mode;
    assign mode = pad_mode_e'({drv_hi[i], drv_lo[i]});

    always_ff @(posedge clk) begin
      if (rst) begin
        pad_out[i] <= 1'b0;
        pad_oe[i]  <= 1'b0;
      end else begin
        unique case (mode)
          PM_INPUT:    begin pad_out[i] <= 1'b0;   pad_oe[i] <= 1'b0;    end
          PM_PUSHPULL: begin pad_out[i] <= dat[i]; pad_oe[i] <= 1'b1;    end
          PM_SINK:     begin pad_out[i] <= 1'b0;   pad_oe[i] <= ~dat[i]; end
          PM_SOURCE:   begin pad_out[i] <= 1'b1;   pad_oe[i] <= dat[i];  end
          default:     begin pad_out[i] <= 1'b0;   pad_oe[i] <= 1'b0;    end
        endcase
      end
    end

    // R2: input mode never drives
    a_r2_input_floats: assert property (@(posedge clk) disable iff (rst)
      (mode == PM_INPUT) |=> !pad_oe[i]);
    // R3: push-pull drives the data bit
    a_r3_pushpull_follows: assert property (@(posedge clk) disable iff (rst)
      (mode == PM_PUSHPULL) |=> (pad_oe[i] && pad_out[i] == $past(dat[i])));
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] raw,
  output logic [N-1:0] synced
);
  logic [N-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      synced <= '0;
    end else begin
      stage1 <= raw;
      synced <= stage1;
    end
  end
endmodule

// File: rtl/gpio_padmode_ctrl.sv
module gpio_padmode_ctrl
  import gpio_padmode_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata,
  input  logic [MAX_PINS-1:0] pad_in,
  output logic [MAX_PINS-1:0] pad_out,
  output logic [MAX_PINS-1:0] pad_oe
);
  localparam int unsigned N = NUM_PINS;
  localparam logic [MAX_PINS-1:0] PIN_MASK = MAX_PINS'((64'd1 << N) - 64'd1);

  initial begin
    if (N < 1 || N > MAX_PINS) $error("NUM_PINS out of range");
  end

  logic         armed;
  logic [N-1:0] drv_hi, drv_lo, out_q, din_q, enc_out, enc_oe;

  function automatic logic hit(input logic [BUS_AW-1:0] ofs);
    return bus_wr && (bus_addr == ofs);
  endfunction

  gpio_guard_lock u_guard (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (hit(OFS_GUARD)),
    .key_in (bus_wdata[KEY_W-1:0]),
    .armed  (armed)
  );

  gpio_drive_regs #(.N(N)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .unlocked (armed),
    .wr_hi    (hit(OFS_DRV_HI)),
    .wr_lo    (hit(OFS_DRV_LO)),
    .clr_hi   (hit(OFS_DRV_HI_CLR)),
    .set_lo   (hit(OFS_DRV_LO_SET)),
    .clr_lo   (hit(OFS_DRV_LO_CLR)),
    .set_out  (hit(OFS_OUT_SET)),
    .clr_out  (hit(OFS_OUT_CLR)),
    .wdata    (bus_wdata[N-1:0]),
    .drv_hi   (drv_hi),
    .drv_lo   (drv_lo),
    .out_q    (out_q)
  );

  gpio_pad_encode #(.N(N)) u_enc (
    .clk     (clk),
    .rst     (rst),
    .drv_hi  (drv_hi),
    .drv_lo  (drv_lo),
    .dat     (out_q),
    .pad_out (enc_out),
    .pad_oe  (enc_oe)
  );

  gpio_in_sync #(.N(N)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .raw    (pad_in[N-1:0]),
    .synced (din_q)
  );

  if (N < MAX_PINS) begin : g_partial
    logic unused_pad_hi;
    assign unused_pad_hi = ^pad_in[MAX_PINS-1:N];
    assign pad_out = {{(MAX_PINS-N){1'b0}}, enc_out};
    assign pad_oe  = {{(MAX_PINS-N){1'b0}}, enc_oe};
  end else begin : g_full
    assign pad_out = enc_out;
    assign pad_oe  = enc_oe;
  end

  always_ff @(posedge clk) begin
    if (rst || !bus_rd) begin
      bus_rdata <= '0;
    end else begin
      unique case (bus_addr)
        OFS_PIN_IN:  bus_rdata <= BUS_DW'(din_q);
        OFS_DRV_HI:  bus_rdata <= BUS_DW'(drv_hi);
        OFS_DRV_LO:  bus_rdata <= BUS_DW'(drv_lo);
        OFS_OUT_SET: bus_rdata <= BUS_DW'(out_q);
        OFS_GUARD:   bus_rdata <= {armed, {(BUS_DW-1){1'b0}}};
        default:     bus_rdata <= '0;
      endcase
    end
  end

  // R10: unpopulated pins never drive
  a_r10_unpopulated_quiet: assert property (@(posedge clk) disable iff (rst)
    ((pad_oe & ~PIN_MASK) == '0) && ((pad_out & ~PIN_MASK) == '0));
  // R11: read data is zero in cycles that follow no read
  a_r11_idle_rdata_zero: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0));
endmodule

// File: tb/gpio_padmode_ctrl_tb_top.sv
module gpio_padmode_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NPINS = 20;
  localparam logic [31:0] MASK = 32'h000F_FFFF;
  localparam logic [15:0] ARM = 16'hD42F;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, pad_in = '0, pad_out, pad_oe;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_padmode_ctrl #(.NUM_PINS(NPINS)) dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  // rows: {mode_hi, mode_lo, data, expect_out, expect_oe}
  localparam logic [4:0] VEC [8] = '{
    5'b00_0_0_0, 5'b00_1_0_0,   // R2
    5'b01_0_0_1, 5'b01_1_1_1,   // R3
    5'b10_0_0_1, 5'b10_1_0_0,   // R4
    5'b11_0_1_0, 5'b11_1_1_1    // R5
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic settle();
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 oe", pad_oe, 32'h0);
    check("R1 out", pad_out, 32'h0);
    rd(8'h08, v); check("R1 mode_hi", v, 32'h0);
    rd(8'h0C, v); check("R1 mode_lo", v, 32'h0);
    rd(8'h14, v); check("R1 data", v, 32'h0);
    rd(8'h60, v); check("R1 guard", v, 32'h0);

    // R6 guard arming
    wr(8'h60, 32'h0000_1234);
    rd(8'h60, v); check("R6 wrong key ignored", v, 32'h0);
    wr(8'h60, {16'hFFFF, ARM});
    rd(8'h60, v); check("R6 armed", v, 32'h8000_0000);
    wr(8'h60, 32'h0000_5555);
    rd(8'h60, v); check("R6 other value holds", v, 32'h8000_0000);

    // R2 R3 R4 R5 table walk
    for (int k = 0; k < 8; k++) begin
      wr(8'h08, VEC[k][4] ? 32'hFFFF_FFFF : 32'h0);
      wr(8'h0C, VEC[k][3] ? 32'hFFFF_FFFF : 32'h0);
      wr(VEC[k][2] ? 8'h14 : 8'h18, 32'hFFFF_FFFF);
      settle();
      check($sformatf("R%0d out row %0d", 2 + k/2, k), pad_out, VEC[k][1] ? MASK : 32'h0);
      check($sformatf("R%0d oe row %0d", 2 + k/2, k), pad_oe, VEC[k][0] ? MASK : 32'h0);
    end

    // R10 upper pins quiet while all populated pins source high
    check("R10 oe upper", pad_oe & ~MASK, 32'h0);
    rd(8'h08, v); check("R10 mode_hi width", v, MASK);

    // R8 set/clear act on ones only
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h14, 32'h0000_0005);
    wr(8'h14, 32'h0000_0002);
    rd(8'h14, v); check("R8 data set", v, 32'h0000_0007);
    wr(8'h18, 32'h0000_0004);
    rd(8'h14, v); check("R8 data clear", v, 32'h0000_0003);
    wr(8'h0C, 32'h0);
    wr(8'h54, 32'h0000_0003);
    wr(8'h58, 32'h0000_0001);
    rd(8'h0C, v); check("R8 mode_lo set/clear", v, 32'h0000_0002);
    wr(8'h50, 32'h0000_00F0);
    rd(8'h08, v); check("R8 mode_hi clear", v, MASK & ~32'hF0);

    // R7 mode writes dropped while disarmed
    wr(8'h60, 32'h0);
    rd(8'h60, v); check("R6 disarmed", v, 32'h0);
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h54, 32'h0000_0100);
    wr(8'h58, 32'h0000_0002);
    wr(8'h50, 32'h0000_000F);
    wr(8'h08, 32'h0);
    rd(8'h0C, v); check("R7 mode_lo kept", v, 32'h0000_0002);
    rd(8'h08, v); check("R7 mode_hi kept", v, MASK & ~32'hF0);
    settle();
    // pin0: mode 10, data 1 -> floats; pin1: mode 11, data 1 -> drives high
    check("R7 pad oe kept", pad_oe & 32'h3, 32'h2);

    // R9 two-flop input path, R10 upper bits read 0
    pad_in = 32'hFFFF_FFFF;
    rd(8'h04, v); check("R9 first read old", v, 32'h0);
    rd(8'h04, v); check("R9 second read old", v, 32'h0);
    rd(8'h04, v); check("R9 third read new / R10 mask", v, MASK);

    // R11 unmapped read and idle rdata
    rd(8'h20, v); check("R11 unmapped", v, 32'h0);
    @(negedge clk);
    check("R11 idle rdata", bus_rdata, 32'h0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule